// File: doc/BRIEF.md
# Quarter-Rate Complex-to-Real Upconverter

This block sits behind a complex baseband datapath and turns each I/Q sample stream into one of three output forms, chosen by a two-bit mode input. In pass mode the samples leave unchanged. In single-rate real mode the stream is rotated by a quarter of the sample rate and only the real part is kept, on the I lane, with the Q lane held at zero. In double-rate real mode the stream is first interpolated by two with a fixed seven-tap half-band filter, then rotated by a quarter of the output rate. The resulting real stream, at twice the clock rate, leaves as two samples per clock: the earlier one on the I lane and the later one on the Q lane.

The rotation uses the repeating sequence 1, j, -1, -j, so the mixer needs only lane selection and saturating negation and no multipliers. Writing a new value on the mode input starts a new segment. The phase counter returns to zero, the filter history is cleared, and in double-rate mode the valid flag stays low until the filter window again holds only samples from the new segment. Every output is registered one clock after the input sample that produces it.

Top module: `iqc_real_upconv`

## Requirements
- R1: While reset is asserted, out_valid is 0 and out_i and out_q are 0.
- R2: In mode code 0 (pass), and also in the unused code 3, out_i and out_q equal in_i and in_q of the previous clock, and out_valid is 1.
- R3: In mode code 1 (single-rate real), with n the index of the sample within its segment (the first sample is n = 0), out_i one clock later equals I, -Q, -I, +Q for n mod 4 = 0, 1, 2, 3, out_q is 0 and out_valid is 1.
- R4: Every negation in the mixer saturates, so an input at the most negative value becomes the most positive value.
- R5: In mode code 2 (double-rate real), samples n = 0, 1 and 2 of a segment give out_valid = 0. For n >= 3, out_valid is 1 and out_i equals +I[n-2] when (n-3) is even and the saturated negation of I[n-2] when (n-3) is odd.
- R6: In mode code 2 with n >= 3, let v = (-Q[n-3] + 9*Q[n-2] + 9*Q[n-1] - Q[n] + 8) shifted right arithmetically by 4 bits and clamped to the data range. out_q equals -v (saturated) when (n-3) is even and +v when (n-3) is odd.
- R7: A sample whose mode code differs from that of the previous clock is sample n = 0 of a new segment. No sample from before it affects any later output, and the rotation phase starts again at 0.
- R8: Whenever out_valid is 0, out_i and out_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one input sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 pass, 1 single-rate real, 2 double-rate real, 3 pass |
| in_i | input | DATA_W | Signed in-phase input sample |
| in_q | input | DATA_W | Signed quadrature input sample |
| out_i | output | DATA_W | Signed I lane, or the first real sample of a pair in double-rate mode |
| out_q | output | DATA_W | Signed Q lane, or the second real sample of a pair in double-rate mode |
| out_valid | output | 1 | Output lanes carry a valid result |

## Verification
The hardest state to reach is a segment restart in double-rate mode while the filter history still holds large values from the previous segment, together with the clamping of the interpolated sample. The bench switches modes after only a few samples, including a quick return to double-rate mode, so any leftover history or phase would show in the first valid pair. It also feeds runs of alternating full-scale Q values, which push the half-band sum past the output range in both directions. Single-rate mode is swept so that every 8-bit I and Q value meets every rotation phase, the most negative value included.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

   typedef enum logic [1:0] {
      IQC_PASS     = 2'd0,
      IQC_REAL1X   = 2'd1,
      IQC_REAL2X   = 2'd2,
      IQC_PASS_ALT = 2'd3
   } iqc_mode_e;

   // Number of rotation phases in the 1, j, -1, -j sequence
   localparam int unsigned IQC_PHASES  = 4;
   localparam int unsigned IQC_PHASE_W = $clog2(IQC_PHASES);

   // Earlier samples needed before the interpolator window is full
   localparam int unsigned IQC_HB_HIST = 3;

endpackage

// File: rtl/iqc_seq_ctrl.sv
module iqc_seq_ctrl
   import iqc_pkg::*;
#(
   parameter int unsigned FILL_MAX = IQC_HB_HIST
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             mode,
   output logic                   restart,
   output logic [IQC_PHASE_W-1:0] phase,
   output logic                   filled
);

   localparam int unsigned FILL_W = $clog2(FILL_MAX + 1);
   localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(FILL_MAX);

   if (FILL_MAX < 1) begin : g_bad_fill
      $error("iqc_seq_ctrl: FILL_MAX must be at least 1");
   end

   logic [1:0]             mode_q;
   logic [IQC_PHASE_W-1:0] phase_q;
   logic [FILL_W-1:0]      fill_q;
   logic [FILL_W-1:0]      fill_eff;

   // A new mode code opens a new segment on this very sample
   assign restart  = (mode != mode_q);
   assign phase    = restart ? '0 : phase_q;
   assign fill_eff = restart ? '0 : fill_q;
   assign filled   = (fill_eff >= FILL_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= IQC_PASS;
         phase_q <= '0;
         fill_q  <= '0;
      end else begin
         mode_q  <= mode;
         phase_q <= phase + 1'b1;
         fill_q  <= (fill_eff == FILL_TOP) ? fill_eff : fill_eff + 1'b1;
      end
   end

endmodule

// File: rtl/iqc_hb_lane.sv
module iqc_hb_lane
   import iqc_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter bit          INTERP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] dout
);

   // The centre-tap lane only needs two earlier samples
   localparam int unsigned DEPTH = INTERP ? IQC_HB_HIST : IQC_HB_HIST - 1;
   localparam int unsigned ACC_W = DATA_W + 6;
   localparam int unsigned SHIFT = 4;

   logic signed [DATA_W-1:0] win   [DEPTH+1];
   logic signed [DATA_W-1:0] dly_q [DEPTH];

   assign win[0] = din;

   for (genvar t = 1; t <= DEPTH; t++) begin : g_win
      assign win[t] = restart ? '0 : dly_q[t-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < DEPTH; t++) dly_q[t] <= '0;
      end else begin
         for (int t = 0; t < DEPTH; t++) dly_q[t] <= win[t];
      end
   end

   if (INTERP) begin : g_interp
      localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (SHIFT - 1));
      localparam logic signed [ACC_W-1:0] HI  = ACC_W'((2 ** (DATA_W - 1)) - 1);
      localparam logic signed [ACC_W-1:0] LO  = -HI - 1;

      function automatic logic signed [ACC_W-1:0] sx(input logic signed [DATA_W-1:0] x);
         return {{(ACC_W - DATA_W){x[DATA_W-1]}}, x};
      endfunction

      logic signed [ACC_W-1:0] inner;
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W-1:0] scaled;

      // Taps -1, 9, 9, -1 over sixteen; times nine done as shift plus add
      assign inner  = sx(win[1]) + sx(win[2]);
      assign acc    = (inner <<< 3) + inner - sx(win[0]) - sx(win[3]) + RND;
      assign scaled = acc >>> SHIFT;

      always_comb begin
         if (scaled > HI)      dout = HI[DATA_W-1:0];
         else if (scaled < LO) dout = LO[DATA_W-1:0];
         else                  dout = scaled[DATA_W-1:0];
      end
   end else begin : g_centre
      assign dout = win[2];
   end

endmodule

// File: rtl/iqc_quarter_rot.sv
module iqc_quarter_rot
   import iqc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [1:0]               mode,
   input  logic [IQC_PHASE_W-1:0]   phase,
   input  logic                     filled,
   input  logic signed [DATA_W-1:0] in_i,
   input  logic signed [DATA_W-1:0] in_q,
   input  logic signed [DATA_W-1:0] hb_centre,
   input  logic signed [DATA_W-1:0] hb_mid,
   output logic signed [DATA_W-1:0] nxt_i,
   output logic signed [DATA_W-1:0] nxt_q,
   output logic                     nxt_valid
);

   localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};

   function automatic logic signed [DATA_W-1:0] neg_sat(input logic signed [DATA_W-1:0] x);
      if (x == MINV) return MAXV;
      return -x;
   endfunction

   iqc_mode_e mode_e;
   logic      pair_odd;

   assign mode_e   = iqc_mode_e'(mode);
   // Pair index is sample index minus three, so odd pairs sit on even samples
   assign pair_odd = ~phase[0];

   always_comb begin
      nxt_i     = '0;
      nxt_q     = '0;
      nxt_valid = 1'b0;
      unique case (mode_e)
         IQC_REAL1X: begin
            nxt_valid = 1'b1;
            unique case (phase)
               2'd0:    nxt_i = in_i;
               2'd1:    nxt_i = neg_sat(in_q);
               2'd2:    nxt_i = neg_sat(in_i);
               default: nxt_i = in_q;
            endcase
         end
         IQC_REAL2X: begin
            if (filled) begin
               nxt_valid = 1'b1;
               nxt_i     = pair_odd ? neg_sat(hb_centre) : hb_centre;
               nxt_q     = pair_odd ? hb_mid : neg_sat(hb_mid);
            end
         end
         default: begin
            nxt_valid = 1'b1;
            nxt_i     = in_i;
            nxt_q     = in_q;
         end
      endcase
   end

endmodule

// File: rtl/iqc_real_upconv.sv
module iqc_real_upconv
   import iqc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode,
   input  logic signed [DATA_W-1:0] in_i,
   input  logic signed [DATA_W-1:0] in_q,
   output logic signed [DATA_W-1:0] out_i,
   output logic signed [DATA_W-1:0] out_q,
   output logic                     out_valid
);

   localparam int unsigned LANES = 2;

   if (DATA_W < 4 || DATA_W > 26) begin : g_bad_width
      $error("iqc_real_upconv: DATA_W must lie between 4 and 26");
   end

   logic                     restart;
   logic [IQC_PHASE_W-1:0]   phase;
   logic                     filled;
   logic signed [DATA_W-1:0] lane_in  [LANES];
   logic signed [DATA_W-1:0] lane_out [LANES];
   logic signed [DATA_W-1:0] nxt_i;
   logic signed [DATA_W-1:0] nxt_q;
   logic                     nxt_valid;

   iqc_seq_ctrl #(
      .FILL_MAX (IQC_HB_HIST)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .restart (restart),
      .phase   (phase),
      .filled  (filled)
   );

   assign lane_in[0] = in_i;
   assign lane_in[1] = in_q;

   // Lane 0 keeps the centre tap, lane 1 forms the half-way sample
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      iqc_hb_lane #(
         .DATA_W (DATA_W),
         .INTERP (l == 1)
      ) u_hb (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (restart),
         .din     (lane_in[l]),
         .dout    (lane_out[l])
      );
   end

   iqc_quarter_rot #(
      .DATA_W (DATA_W)
   ) u_rot (
      .mode      (mode),
      .phase     (phase),
      .filled    (filled),
      .in_i      (in_i),
      .in_q      (in_q),
      .hb_centre (lane_out[0]),
      .hb_mid    (lane_out[1]),
      .nxt_i     (nxt_i),
      .nxt_q     (nxt_q),
      .nxt_valid (nxt_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_i     <= '0;
         out_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_i     <= nxt_i;
         out_q     <= nxt_q;
         out_valid <= nxt_valid;
      end
   end

endmodule

// File: rtl/iqc_real_upconv_chk.sv
module iqc_real_upconv_chk
   import iqc_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0]               mode,
   input logic signed [DATA_W-1:0] in_i,
   input logic signed [DATA_W-1:0] in_q,
   input logic signed [DATA_W-1:0] out_i,
   input logic signed [DATA_W-1:0] out_q,
   input logic                     out_valid
);

   // R2: pass mode forwards the previous sample
   a_r2_pass_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode) == IQC_PASS)
         |-> (out_i == $past(in_i) && out_q == $past(in_q)));

   // R3: single-rate real mode silences the Q lane
   a_r3_q_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode) == IQC_REAL1X) |-> (out_q == '0));

   // R5: a valid double-rate pair needs four samples of the same segment
   a_r5_fill_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(mode) == IQC_REAL2X)
         |-> ($past(mode, 2) == IQC_REAL2X && $past(mode, 3) == IQC_REAL2X
              && $past(mode, 4) == IQC_REAL2X));

   // R7: entering double-rate mode never yields a valid pair at once
   a_r7_restart_blank: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == IQC_REAL2X && $past(mode) != $past(mode, 2)) |-> !out_valid);

   // R8: invalid outputs stay at zero
   a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_i == '0 && out_q == '0));

endmodule

bind iqc_real_upconv iqc_real_upconv_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .in_i      (in_i),
   .in_q      (in_q),
   .out_i     (out_i),
   .out_q     (out_q),
   .out_valid (out_valid)
);

// File: tb/iqc_real_upconv_test.sv
module iqc_real_upconv_test;

   localparam int W    = 8;
   localparam int MAXV = (1 << (W - 1)) - 1;
   localparam int MINV = -(1 << (W - 1));

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [1:0]          mode = 2'd0;
   logic signed [W-1:0] in_i = '0;
   logic signed [W-1:0] in_q = '0;
   logic signed [W-1:0] out_i;
   logic signed [W-1:0] out_q;
   logic                out_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Bench model state
   int         seg = 0;
   logic [1:0] bm  = 2'd0;
   int         hI [4];
   int         hQ [4];

   always #5 clk = ~clk;

   iqc_real_upconv #(.DATA_W(W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_i     (out_i),
      .out_q     (out_q),
      .out_valid (out_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (segment sample %0d, mode %0d)",
                  req, act, exp, seg, bm);
      end
   endtask

   function automatic int nsat(input int x);
      return (x == MINV) ? MAXV : -x;
   endfunction

   function automatic int clampv(input int x);
      if (x > MAXV) return MAXV;
      if (x < MINV) return MINV;
      return x;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic step(input logic [1:0] m, input int iv, input int qv);
      int ei, eq, ev, k, v;
      @(negedge clk);
      mode = m;
      in_i = W'(iv);
      in_q = W'(qv);
      if (m != bm) begin
         seg = 0;
         for (int t = 0; t < 4; t++) begin
            hI[t] = 0;
            hQ[t] = 0;
         end
      end
      bm = m;
      for (int t = 3; t > 0; t--) begin
         hI[t] = hI[t-1];
         hQ[t] = hQ[t-1];
      end
      hI[0] = iv;
      hQ[0] = qv;
      @(posedge clk);
      #2;
      ei = 0; eq = 0; ev = 1;
      case (m)
         2'd1: begin
            case (seg % 4)
               0: ei = iv;
               1: ei = nsat(qv);
               2: ei = nsat(iv);
               default: ei = qv;
            endcase
            chk("R3 single-rate I", int'(out_i), ei);
            chk("R3 single-rate Q zero", int'(out_q), 0);
            chk("R3 valid", int'(out_valid), 1);
         end
         2'd2: begin
            if (seg < 3) begin
               chk("R5 warm-up valid low", int'(out_valid), 0);
               chk("R8 idle I zero", int'(out_i), 0);
               chk("R8 idle Q zero", int'(out_q), 0);
            end else begin
               k  = seg - 3;
               v  = clampv((-hQ[3] + 9 * hQ[2] + 9 * hQ[1] - hQ[0] + 8) >>> 4);
               ei = (k % 2 == 1) ? nsat(hI[2]) : hI[2];
               eq = (k % 2 == 1) ? v : nsat(v);
               chk("R5 double-rate first sample", int'(out_i), ei);
               chk("R6 double-rate second sample", int'(out_q), eq);
               chk("R5 valid", int'(out_valid), ev);
            end
         end
         default: begin
            chk("R2 pass I", int'(out_i), iv);
            chk("R2 pass Q", int'(out_q), qv);
            chk("R2 valid", int'(out_valid), 1);
         end
      endcase
      seg++;
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int t = 0; t < 4; t++) begin
         hI[t] = 0;
         hQ[t] = 0;
      end
      // R1: reset state, with non-zero inputs applied
      mode = 2'd1;
      in_i = 8'sd55;
      in_q = -8'sd17;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset valid", int'(out_valid), 0);
      chk("R1 reset I", int'(out_i), 0);
      chk("R1 reset Q", int'(out_q), 0);
      @(negedge clk);
      mode  = 2'd0;
      rst_n = 1'b1;
      seg   = 0;
      bm    = 2'd0;

      // R2: pass mode over every I value
      for (int s = 0; s < 256; s++) step(2'd0, s - 128, 127 - s);

      // R3, R4: every value in every rotation phase
      for (int s = 0; s < 1024; s++) step(2'd1, (s >> 2) - 128, (((s >> 2) ^ 165) & 255) - 128);

      // R5, R6: double-rate with full-scale bursts to force clamping
      for (int s = 0; s < 1200; s++) begin
         int qv;
         if (s % 64 < 12) qv = (s % 4 == 0 || s % 4 == 3) ? MINV : MAXV;
         else             qv = ((s * 53 + 17) & 255) - 128;
         step(2'd2, ((s * 29) & 255) - 128, qv);
      end

      // R7: short segments with large leftover history
      for (int s = 0; s < 5; s++) step(2'd2, MAXV, MINV);
      for (int s = 0; s < 2; s++) step(2'd0, 40 + s, -40 - s);
      for (int s = 0; s < 7; s++) step(2'd2, 3 * s - 9, 5 * s - 11);
      for (int s = 0; s < 6; s++) step(2'd1, 10 + s, 20 + s);
      for (int s = 0; s < 4; s++) step(2'd3, MINV + s, MAXV - s);
      for (int s = 0; s < 5; s++) step(2'd1, -30 + s, 60 - s);
      for (int s = 0; s < 2; s++) step(2'd2, MINV, MINV);
      for (int s = 0; s < 6; s++) step(2'd2, 7 * s, -6 * s);

      finish_run();
   end

endmodule